// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit

A 36-bit first-in first-out buffer that carries words from a write clock domain to a read clock domain. The two clocks may be unrelated or identical, and a write and a read may land on the same edge. The storage depth is `2**ADDR_W` words. Write and read pointers cross between the domains as Gray code through two-flop synchronizers. Occupancy, full and almost-full are therefore judged on the write side, and empty and almost-empty on the read side.

A full reset empties the buffer, zeroes the read data register and latches the configuration on the edge that releases it. The configuration holds the flag offset selection and the timing mode. A partial reset empties the buffer and keeps the configuration. With the retransmit mode pin high, the partial-reset pin instead rewinds only the read pointer, so words already written are read out again. Two read timings are available. Standard timing presents a word on the clock after it is requested. First-word-fall-through timing pushes the oldest word to the output without a request.

Both data sides use valid/ready. The write side accepts a word on a `wr_clk` edge where `in_valid` and `in_ready` are both high. `in_ready` low is back-pressure, and a word offered then is dropped rather than queued, so the source must hold it. The read side transfers on a `rd_clk` edge where `out_valid` and `out_ready` are both high. In fall-through timing the consumer back-pressures by holding `out_ready` low, and the presented word then stays put.

Top module: `dcfifo_rt`

## Requirements
- R1: After full reset is released, `out_data` is zero, `out_valid` is low, `in_ready` is high, `almost_empty` is high and `almost_full` is low.
- R2: `ofs_sel` and `fwft_sel` are captured on the edge that releases full reset. Changing them later has no effect. The encoding of `ofs_sel` is 0→8, 1→16, 2→64, 3→256, and 4 to 7→1024.
- R3: Words leave in the order they were accepted, whatever the ratio of the two clocks.
- R4: While `in_ready` is low (FIFO holds `2**ADDR_W` words), an offered word is ignored and never read out.
- R5: A read request while the FIFO is empty is ignored: `out_data` keeps its value and no pointer moves.
- R6: With `fwft_sel` latched as 0 (standard), `out_valid` is high exactly when the read side sees stored words. An accepted read loads the next word into `out_data` at that `rd_clk` edge, and `out_data` changes at no other time.
- R7: With `fwft_sel` latched as 1 (fall-through), the oldest word appears on `out_data` with `out_valid` high and no request. While `out_ready` is low, `out_data` and `out_valid` hold.
- R8: `almost_empty` is high when the read side sees at most `offset` words in storage. In fall-through mode this count excludes a word already presented.
- R9: `almost_full` is high when the write side sees at least `2**ADDR_W − offset` words stored, and the stored count never exceeds `2**ADDR_W`.
- R10: `prst_n` low with `rt_mode` low empties the FIFO and zeroes `out_data`, and the latched offset and timing mode stay in force.
- R11: `prst_n` low with `rt_mode` high rewinds only the read pointer to the first location. Words written since the last reset are read again, and the write pointer is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Full reset, active low, sampled in both domains |
| prst_n | input | 1 | Partial reset or retransmit request, active low |
| rt_mode | input | 1 | 1: `prst_n` rewinds the read pointer; 0: `prst_n` empties the FIFO |
| ofs_sel | input | 3 | Flag offset selection, latched at full reset release |
| fwft_sel | input | 1 | 1: fall-through timing, 0: standard; latched at full reset release |
| in_valid | input | 1 | Write word offered |
| in_ready | output | 1 | FIFO can accept (not full / input-ready) |
| in_data | input | 36 | Write word |
| almost_full | output | 1 | Write-side programmable flag |
| out_valid | output | 1 | Standard: not empty; fall-through: output-ready |
| out_ready | input | 1 | Read request / consumer accepts |
| out_data | output | 36 | Read data register |
| almost_empty | output | 1 | Read-side programmable flag |

## Verification
The hardest state to reach from the ports is a completely full array that receives further offered words. Filling it needs every one of `2**ADDR_W` locations written with the reader idle. Then, with `in_ready` low, a distinctive word is offered for several cycles, the whole array is drained and compared, and `out_valid` must stay low afterwards. Retransmit is also hard to reach, since it only shows itself after a drain. The bench empties the FIFO, rewinds with `rt_mode` high, reads the same words a second time, and then writes a fresh word to prove the write pointer was untouched.

// File: rtl/dcfifo_rt_pkg.sv
package dcfifo_rt_pkg;

  typedef struct packed {
    logic       fwft;
    logic [2:0] sel;
  } rd_cfg_t;

  // Flag offset lookup: 8,16,64,256, then 1024 for all larger codes.
  function automatic logic [15:0] ofs_value(input logic [2:0] s);
    case (s)
      3'd0:    ofs_value = 16'd8;
      3'd1:    ofs_value = 16'd16;
      3'd2:    ofs_value = 16'd64;
      3'd3:    ofs_value = 16'd256;
      default: ofs_value = 16'd1024;
    endcase
  endfunction

endpackage

// File: rtl/dcfifo_rt_sync.sv
module dcfifo_rt_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n || clr) st[i] <= '0;
        else if (i == 0)   st[i] <= d;
        else               st[i] <= st[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/dcfifo_rt_mem.sv
module dcfifo_rt_mem #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 11
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcfifo_rt_wside.sv
module dcfifo_rt_wside
  import dcfifo_rt_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              prst_n,
  input  logic              rt_mode,
  input  logic [2:0]        ofs_sel,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              almost_full,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray,
  input  logic [ADDR_W:0]   rgray_async
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [2:0]       sel_q;
  logic [PTR_W-1:0] wbin, wbin_nx, rs_gray, rs_bin, used;
  logic [15:0]      ofs;
  logic             clr, full;

  assign clr = !prst_n && !rt_mode;

  always_ff @(posedge wr_clk) begin
    if (!rst_n) sel_q <= ofs_sel;
  end

  dcfifo_rt_sync #(.W(PTR_W), .STAGES(2)) u_rsync (
    .clk(wr_clk), .rst_n(rst_n), .clr(clr), .d(rgray_async), .q(rs_gray)
  );

  always_comb begin
    rs_bin[PTR_W-1] = rs_gray[PTR_W-1];
    for (int i = PTR_W-2; i >= 0; i--) rs_bin[i] = rs_bin[i+1] ^ rs_gray[i];
  end

  assign used        = wbin - rs_bin;
  assign full        = (used == PTR_W'(DEPTH));
  assign in_ready    = !full;
  assign ofs         = ofs_value(sel_q);
  assign almost_full = 32'(used) >= (32'(DEPTH) - 32'(ofs));
  assign we          = in_valid && !full && rst_n && !clr;
  assign waddr       = wbin[ADDR_W-1:0];
  assign wbin_nx     = wbin + 1'b1;

  always_ff @(posedge wr_clk) begin
    if (!rst_n || clr) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (we) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  a_r4_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n || clr)
    (in_valid && !in_ready) |=> $stable(wbin));

  a_r3_wgray_step: assert property (@(posedge wr_clk) disable iff (!rst_n || clr)
    $countones(wgray ^ $past(wgray)) <= 1);

  a_r9_bound: assert property (@(posedge wr_clk) disable iff (!rst_n || clr)
    32'(used) <= 32'(DEPTH));
endmodule

// File: rtl/dcfifo_rt_rside.sv
module dcfifo_rt_rside
  import dcfifo_rt_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 11
) (
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              prst_n,
  input  logic              rt_mode,
  input  logic [2:0]        ofs_sel,
  input  logic              fwft_sel,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              almost_empty,
  output logic [ADDR_W-1:0] raddr,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W:0]   rgray,
  input  logic [ADDR_W:0]   wgray_async
);
  localparam int PTR_W = ADDR_W + 1;

  rd_cfg_t          cfg_q;
  logic [PTR_W-1:0] rbin, rbin_nx, ws_gray, ws_bin, avail;
  logic [DATA_W-1:0] out_q;
  logic [15:0]      ofs;
  logic             clr, rewind, mem_ne, load, ov;

  assign clr    = !prst_n && !rt_mode;
  assign rewind = !prst_n && rt_mode;

  always_ff @(posedge rd_clk) begin
    if (!rst_n) cfg_q <= '{fwft: fwft_sel, sel: ofs_sel};
  end

  dcfifo_rt_sync #(.W(PTR_W), .STAGES(2)) u_wsync (
    .clk(rd_clk), .rst_n(rst_n), .clr(clr), .d(wgray_async), .q(ws_gray)
  );

  always_comb begin
    ws_bin[PTR_W-1] = ws_gray[PTR_W-1];
    for (int i = PTR_W-2; i >= 0; i--) ws_bin[i] = ws_bin[i+1] ^ ws_gray[i];
  end

  assign avail   = ws_bin - rbin;
  assign mem_ne  = (avail != '0);
  assign load    = cfg_q.fwft ? (mem_ne && (!ov || out_ready)) : (mem_ne && out_ready);
  assign rbin_nx = rbin + 1'b1;
  assign raddr   = rbin[ADDR_W-1:0];
  assign ofs     = ofs_value(cfg_q.sel);

  always_ff @(posedge rd_clk) begin
    if (!rst_n || clr) begin
      rbin  <= '0;
      rgray <= '0;
      out_q <= '0;
      ov    <= 1'b0;
    end else if (rewind) begin
      rbin  <= '0;
      rgray <= '0;
      ov    <= 1'b0;
    end else begin
      if (load) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
        out_q <= rdata;
        ov    <= 1'b1;
      end else if (out_ready) begin
        ov    <= 1'b0;
      end
    end
  end

  assign out_valid    = cfg_q.fwft ? ov : mem_ne;
  assign out_data     = out_q;
  assign almost_empty = 32'(avail) <= 32'(ofs);

  a_r5_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n || clr || rewind)
    !mem_ne |=> $stable(rbin));

  a_r7_fwft_hold: assert property (@(posedge rd_clk) disable iff (!rst_n || clr || rewind)
    (cfg_q.fwft && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r6_std_hold: assert property (@(posedge rd_clk) disable iff (!rst_n || clr || rewind)
    (!cfg_q.fwft && !(out_valid && out_ready)) |=> $stable(out_data));

  a_r3_rgray_step: assert property (@(posedge rd_clk) disable iff (!rst_n || clr || rewind)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcfifo_rt.sv
module dcfifo_rt #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 11
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              prst_n,
  input  logic              rt_mode,
  input  logic [2:0]        ofs_sel,
  input  logic              fwft_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              almost_full,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              almost_empty
);
  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] rdata;
  logic [ADDR_W:0]   wgray, rgray;

  dcfifo_rt_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(in_data),
    .raddr(raddr), .rdata(rdata)
  );

  dcfifo_rt_wside #(.ADDR_W(ADDR_W)) u_wside (
    .wr_clk(wr_clk), .rst_n(rst_n), .prst_n(prst_n), .rt_mode(rt_mode),
    .ofs_sel(ofs_sel), .in_valid(in_valid), .in_ready(in_ready),
    .almost_full(almost_full), .we(we), .waddr(waddr),
    .wgray(wgray), .rgray_async(rgray)
  );

  dcfifo_rt_rside #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rside (
    .rd_clk(rd_clk), .rst_n(rst_n), .prst_n(prst_n), .rt_mode(rt_mode),
    .ofs_sel(ofs_sel), .fwft_sel(fwft_sel), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .almost_empty(almost_empty),
    .raddr(raddr), .rdata(rdata), .rgray(rgray), .wgray_async(wgray)
  );
endmodule

// File: tb/tb_dcfifo_rt.sv
module tb_dcfifo_rt;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int ADDR_W    = 11;
  localparam int DEPTH     = 1 << ADDR_W;

  logic wr_clk = 0, rd_clk = 0;
  logic rst_n = 0, prst_n = 1, rt_mode = 0, fwft_sel = 0;
  logic [2:0] ofs_sel = 3'd0;
  logic in_valid = 0, out_ready = 0;
  logic [35:0] in_data = '0;
  logic in_ready, almost_full, out_valid, almost_empty;
  logic [35:0] out_data;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  dcfifo_rt #(.DATA_W(36), .ADDR_W(ADDR_W)) dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .prst_n(prst_n),
    .rt_mode(rt_mode), .ofs_sel(ofs_sel), .fwft_sel(fwft_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .almost_full(almost_full), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .almost_empty(almost_empty)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic full_reset(input logic [2:0] sel, input logic fw);
    @(negedge rd_clk);
    rst_n = 0; prst_n = 1; rt_mode = 0; in_valid = 0; out_ready = 0;
    ofs_sel = sel; fwft_sel = fw;
    repeat (6) @(negedge rd_clk);
    rst_n = 1;
    ofs_sel = 3'd4; fwft_sel = ~fw;   // later changes must be ignored (R2)
    repeat (4) @(negedge rd_clk);
  endtask

  task automatic push(input logic [35:0] w);
    @(negedge wr_clk);
    while (!in_ready) @(negedge wr_clk);
    in_data = w; in_valid = 1;
    @(negedge wr_clk);
    in_valid = 0;
  endtask

  task automatic pop_std(output logic [35:0] d);
    @(negedge rd_clk);
    while (!out_valid) @(negedge rd_clk);
    out_ready = 1;
    @(negedge rd_clk);
    out_ready = 0;
    d = out_data;
  endtask

  task automatic pop_fwft(output logic [35:0] d);
    @(negedge rd_clk);
    while (!out_valid) @(negedge rd_clk);
    d = out_data;
    out_ready = 1;
    @(negedge rd_clk);
    out_ready = 0;
  endtask

  task automatic t_reset_state();
    full_reset(3'd0, 1'b0);
    chk("R1 out_data", out_data, 36'h0);
    chk("R1 out_valid", {35'b0, out_valid}, 36'h0);
    chk("R1 in_ready", {35'b0, in_ready}, 36'h1);
    chk("R1 almost_empty", {35'b0, almost_empty}, 36'h1);
    chk("R1 almost_full", {35'b0, almost_full}, 36'h0);
  endtask

  task automatic t_order_std();
    logic [35:0] d;
    for (int i = 0; i < 20; i++) push(36'hA0000_0000 + 36'(i * 7));
    for (int i = 0; i < 20; i++) begin
      pop_std(d);
      chk("R3 R6 order", d, 36'hA0000_0000 + 36'(i * 7));
    end
    repeat (4) @(negedge rd_clk);
    chk("R6 out_valid after drain", {35'b0, out_valid}, 36'h0);
  endtask

  task automatic t_empty_read();
    logic [35:0] last, d;
    last = out_data;
    @(negedge rd_clk);
    out_ready = 1;
    repeat (5) @(negedge rd_clk);
    out_ready = 0;
    chk("R5 out_data held", out_data, last);
    chk("R5 out_valid low", {35'b0, out_valid}, 36'h0);
    push(36'h123456789);
    pop_std(d);
    chk("R5 next word", d, 36'h123456789);
  endtask

  task automatic t_almost_empty();
    logic [35:0] d;
    for (int i = 0; i < 8; i++) push(36'(i));
    repeat (5) @(negedge rd_clk);
    chk("R8 aempty at 8", {35'b0, almost_empty}, 36'h1);
    push(36'd8);
    repeat (5) @(negedge rd_clk);
    chk("R8 aempty at 9", {35'b0, almost_empty}, 36'h0);
    for (int i = 0; i < 9; i++) pop_std(d);
  endtask

  task automatic t_full();
    logic [35:0] d;
    full_reset(3'd0, 1'b0);
    for (int i = 0; i < DEPTH - 9; i++) push(36'h300000000 + 36'(i));
    chk("R9 afull below", {35'b0, almost_full}, 36'h0);
    push(36'h300000000 + 36'(DEPTH - 9));
    chk("R9 afull at threshold", {35'b0, almost_full}, 36'h1);
    for (int i = DEPTH - 8; i < DEPTH; i++) push(36'h300000000 + 36'(i));
    chk("R4 in_ready low when full", {35'b0, in_ready}, 36'h0);
    @(negedge wr_clk);
    in_data = 36'hDEADBEEF0; in_valid = 1;
    repeat (4) @(negedge wr_clk);
    in_valid = 0;
    for (int i = 0; i < DEPTH; i++) begin
      pop_std(d);
      chk("R3 R4 drain", d, 36'h300000000 + 36'(i));
    end
    repeat (6) @(negedge rd_clk);
    chk("R4 dropped word absent", {35'b0, out_valid}, 36'h0);
  endtask

  task automatic t_config_hold();
    logic [35:0] d;
    full_reset(3'd1, 1'b0);
    for (int i = 0; i < 16; i++) push(36'(i));
    repeat (5) @(negedge rd_clk);
    chk("R2 offset16 at 16", {35'b0, almost_empty}, 36'h1);
    push(36'd16);
    repeat (5) @(negedge rd_clk);
    chk("R2 offset16 at 17", {35'b0, almost_empty}, 36'h0);
    @(negedge rd_clk);
    chk("R2 std mode kept", {35'b0, out_valid}, 36'h1);
    pop_std(d);
    chk("R2 std pop", d, 36'h0);
  endtask

  task automatic t_partial();
    @(negedge rd_clk);
    rt_mode = 0; prst_n = 0;
    repeat (6) @(negedge rd_clk);
    prst_n = 1;
    repeat (4) @(negedge rd_clk);
    chk("R10 out_data cleared", out_data, 36'h0);
    chk("R10 out_valid low", {35'b0, out_valid}, 36'h0);
    chk("R10 in_ready", {35'b0, in_ready}, 36'h1);
    for (int i = 0; i < 16; i++) push(36'(i + 100));
    repeat (5) @(negedge rd_clk);
    chk("R10 offset kept at 16", {35'b0, almost_empty}, 36'h1);
    push(36'd200);
    repeat (5) @(negedge rd_clk);
    chk("R10 offset kept at 17", {35'b0, almost_empty}, 36'h0);
  endtask

  task automatic t_fwft();
    logic [35:0] d;
    full_reset(3'd0, 1'b1);
    push(36'h111); push(36'h222); push(36'h333);
    repeat (6) @(negedge rd_clk);
    chk("R7 falls through valid", {35'b0, out_valid}, 36'h1);
    chk("R7 falls through data", out_data, 36'h111);
    repeat (5) @(negedge rd_clk);
    chk("R7 held under backpressure", out_data, 36'h111);
    pop_fwft(d); chk("R7 R3 w0", d, 36'h111);
    pop_fwft(d); chk("R7 R3 w1", d, 36'h222);
    pop_fwft(d); chk("R7 R3 w2", d, 36'h333);
    repeat (3) @(negedge rd_clk);
    chk("R7 out_valid low", {35'b0, out_valid}, 36'h0);
  endtask

  task automatic t_retransmit();
    logic [35:0] d;
    full_reset(3'd0, 1'b0);
    for (int i = 0; i < 4; i++) push(36'h7700 + 36'(i));
    for (int i = 0; i < 4; i++) pop_std(d);
    repeat (4) @(negedge rd_clk);
    chk("R11 empty before rewind", {35'b0, out_valid}, 36'h0);
    @(negedge rd_clk);
    rt_mode = 1; prst_n = 0;
    repeat (6) @(negedge rd_clk);
    prst_n = 1;
    @(negedge rd_clk);
    rt_mode = 0;
    for (int i = 0; i < 4; i++) begin
      pop_std(d);
      chk("R11 replay", d, 36'h7700 + 36'(i));
    end
    push(36'h7799);
    pop_std(d);
    chk("R11 write pointer kept", d, 36'h7799);
  endtask

  initial begin
    #(WR_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_order_std();
    t_empty_read();
    t_almost_empty();
    t_full();
    t_config_hold();
    t_partial();
    t_fwft();
    t_retransmit();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule